// File: doc/BRIEF.md
# Audio Transmit Interrupt Status Unit

This block collects event notifications from a stereo audio serial transmitter and turns them into one level-sensitive interrupt for the processor. Each event is a one-cycle pulse on a hardware input. It sets a sticky flag, and software clears that flag by writing a 1 to its bit. A mask register selects which flags can drive the interrupt line.

The unit also records why the transmitter failed. When the first error arrives, its 4-bit cause code is latched. That code then holds until software clears the error flag, and at that point it returns to a dedicated "no error" value. The status word also carries the transmitter's busy level. Software polls this bit before it changes any transmitter setting, because busy can stay high after a suspend.

Software reaches the unit through a small word-addressed register port. Writes take effect on the clock edge. Reads are combinational from the current state.

Top module: `aud_irq_unit`

## Requirements
- R1: After reset (active-low `rst_ni`), the state is as follows: all nine flags are 0, the mask is 0, the error cause is 0xF and `irq_o` is 0.
- R2: A pulse on `evt_i[k]` (k = 0..7) sets status bit k one cycle later. The bit stays set until software clears it. The bit order is fixed: 0 left done, 1 left space, 2 left half, 3 right done, 4 right space, 5 right half, 6 paused, 7 no data.
- R3: A write to address 0 clears each status bit 0..8 whose write-data bit is 1. Bits written with 0 keep their value.
- R4: If a hardware set and a software clear hit the same bit in the same cycle, the bit ends up set.
- R5: The mask register sits at address 1, bits 8:0. It is read/write and resets to 0. Its other read bits are 0.
- R6: `irq_o` is a register. Its value equals the OR over bits 0..8 of (flag AND mask), taken one cycle earlier.
- R7: A pulse on `err_i` sets status bit 8. If no error is already recorded, the same edge latches `err_code_i` into status bits 27:24. The defined codes are 11 (left underflow), 12 (right underflow), 13 (left full write) and 14 (right full write).
- R8: While bit 8 stays set, later errors do not change bits 27:24.
- R9: When software clears bit 8, bits 27:24 return to 0xF. If an error arrives in the same cycle as that clear, bit 8 stays set and the new code is latched.
- R10: Status bit 28 shows the current value of `busy_i`.
- R11: Software writes do not affect bits 28:24 of the status word. Status bits 31:29 and 23:9 always read 0.
- R12: Addresses 2 and 3 read as 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Word address (0 status, 1 mask) |
| reg_wdata_i | input | 9 | Write data for the writable bits |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` |
| evt_i | input | 8 | Event pulses for status bits 0..7 |
| err_i | input | 1 | Error pulse |
| err_code_i | input | 4 | Cause code that accompanies `err_i` |
| busy_i | input | 1 | Transmitter busy level |
| irq_o | output | 1 | Processor interrupt |

## Verification
Two pairs of functions can fall in the same cycle:
- A hardware set and a software clear of the same flag.
- A new error and the software clear of the error flag.

Directed steps pulse an event or `err_i` in the very cycle that a write-1 hits the same bit. The expected result is judged against the set-wins rule, and for the error pair against the capture of the new code. A long randomized phase with sparse pulses and frequent writes then produces both collisions many more times. A behavioural model checks the status word, mask and interrupt on every clock.

// File: rtl/aud_irq_pkg.sv
package aud_irq_pkg;
  parameter int NUM_EVT   = 9;
  parameter int CAUSE_W   = 4;
  parameter int DATA_W    = 32;
  parameter int AW        = 2;

  localparam int ERR_BIT   = NUM_EVT - 1;
  localparam int HW_EVT    = NUM_EVT - 1;
  localparam int CAUSE_LSB = 24;
  localparam int BUSY_BIT  = CAUSE_LSB + CAUSE_W;
  localparam logic [CAUSE_W-1:0] CAUSE_NONE = '1;

  localparam int ADDR_STATUS = 0;
  localparam int ADDR_MASK   = 1;
endpackage

// File: rtl/aud_irq_flag_bank.sv
module aud_irq_flag_bank #(
  parameter int N = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         flags_o[g] <= 1'b0;
      else if (set_i[g])   flags_o[g] <= 1'b1;  // set beats clear
      else if (clr_i[g])   flags_o[g] <= 1'b0;
    end

    a_r4_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] |=> flags_o[g]);
    a_r3_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[g] && !set_i[g]) |=> !flags_o[g]);
    a_r3_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_i[g] && !set_i[g]) |=> (flags_o[g] == $past(flags_o[g])));
  end
endmodule

// File: rtl/aud_irq_err_capture.sv
module aud_irq_err_capture
  import aud_irq_pkg::*;
#(
  parameter int W = CAUSE_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         err_i,
  input  logic [W-1:0] code_i,
  input  logic         flag_i,
  input  logic         clr_i,
  output logic [W-1:0] cause_o
);
  localparam logic [W-1:0] NONE = '1;

  logic take_new;
  assign take_new = err_i && (!flag_i || clr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cause_o <= NONE;
    else if (take_new) cause_o <= code_i;
    else if (clr_i)    cause_o <= NONE;
  end

  a_r8_first_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_i && !clr_i) |=> $stable(cause_o));
  a_r9_idle_none: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_i |-> (cause_o == NONE));
  a_r9_clear_race: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_i && clr_i) |=> (cause_o == $past(code_i)));
endmodule

// File: rtl/aud_irq_mask_gate.sv
module aud_irq_mask_gate #(
  parameter int N = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [N-1:0] wdata_i,
  input  logic [N-1:0] flags_i,
  output logic [N-1:0] mask_o,
  output logic         irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_o <= '0;
    else if (wr_i) mask_o <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |(flags_i & mask_o);
  end

  a_r5_mask_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(mask_o));
  a_r6_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_i == '0) |=> !irq_o);
endmodule

// File: rtl/aud_irq_unit.sv
module aud_irq_unit
  import aud_irq_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_wr_i,
  input  logic [AW-1:0]       reg_addr_i,
  input  logic [NUM_EVT-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]   reg_rdata_o,
  input  logic [HW_EVT-1:0]   evt_i,
  input  logic                err_i,
  input  logic [CAUSE_W-1:0]  err_code_i,
  input  logic                busy_i,
  output logic                irq_o
);
  logic               sel_status, sel_mask;
  logic [NUM_EVT-1:0] clr_vec, set_vec, flags, mask;
  logic [CAUSE_W-1:0] cause;

  assign sel_status = (reg_addr_i == AW'(ADDR_STATUS));
  assign sel_mask   = (reg_addr_i == AW'(ADDR_MASK));
  assign clr_vec    = (reg_wr_i && sel_status) ? reg_wdata_i : '0;
  assign set_vec    = {err_i, evt_i};

  aud_irq_flag_bank #(.N(NUM_EVT)) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (set_vec),
    .clr_i   (clr_vec),
    .flags_o (flags)
  );

  aud_irq_err_capture #(.W(CAUSE_W)) u_err (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .err_i   (err_i),
    .code_i  (err_code_i),
    .flag_i  (flags[ERR_BIT]),
    .clr_i   (clr_vec[ERR_BIT]),
    .cause_o (cause)
  );

  aud_irq_mask_gate #(.N(NUM_EVT)) u_gate (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (reg_wr_i && sel_mask),
    .wdata_i (reg_wdata_i),
    .flags_i (flags),
    .mask_o  (mask),
    .irq_o   (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (sel_status) begin
      reg_rdata_o[NUM_EVT-1:0]                 = flags;
      reg_rdata_o[CAUSE_LSB +: CAUSE_W]        = cause;
      reg_rdata_o[BUSY_BIT]                    = busy_i;
    end else if (sel_mask) begin
      reg_rdata_o[NUM_EVT-1:0]                 = mask;
    end
  end

  a_r11_cause_ro: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!err_i && !clr_vec[ERR_BIT]) |=> $stable(cause));
  a_r12_unmapped_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_status && !sel_mask) |-> (reg_rdata_o == '0));
endmodule

// File: tb/tb_aud_irq_unit.sv
`timescale 1ns/1ps
module tb_aud_irq_unit;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [8:0]  reg_wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  evt = '0;
  logic        err = 1'b0;
  logic [3:0]  err_code = 4'd11;
  logic        busy = 1'b0;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // reference state
  logic [8:0] m_flags = '0;
  logic [8:0] m_mask  = '0;
  logic [3:0] m_cause = 4'hF;
  logic       m_irq   = 1'b0;

  always #2 clk = ~clk;

  aud_irq_unit dut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(rdata), .evt_i(evt), .err_i(err),
    .err_code_i(err_code), .busy_i(busy), .irq_o(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic compare_now();
    chk("R6 irq", {31'd0, irq}, {31'd0, m_irq});
    case (reg_addr)
      2'd0: begin
        chk("R2 R3 R4 event flags", {24'd0, rdata[7:0]}, {24'd0, m_flags[7:0]});
        chk("R7 error flag", {31'd0, rdata[8]}, {31'd0, m_flags[8]});
        chk("R8 R9 error cause", {28'd0, rdata[27:24]}, {28'd0, m_cause});
        chk("R10 busy", {31'd0, rdata[28]}, {31'd0, busy});
        chk("R11 reserved status bits", {11'd0, rdata[31:29], rdata[23:9]}, 32'd0);
      end
      2'd1: begin
        chk("R5 mask", {23'd0, rdata[8:0]}, {23'd0, m_mask});
        chk("R5 mask upper bits", {9'd0, rdata[31:9]}, 32'd0);
      end
      default: chk("R12 unmapped read", rdata, 32'd0);
    endcase
  endtask

  // drive one cycle at negedge, compare, advance model at posedge
  task automatic drv(logic wr, logic [1:0] a, logic [8:0] wd, logic [7:0] e,
                     logic er, logic [3:0] code, logic b);
    logic [8:0] clr, nflags, nmask;
    logic [3:0] ncause;
    logic       nirq;
    @(negedge clk);
    reg_wr = wr; reg_addr = a; reg_wdata = wd; evt = e; err = er;
    err_code = code; busy = b;
    #0.5;
    compare_now();
    clr    = (wr && a == 2'd0) ? wd : 9'd0;
    nflags = (m_flags & ~clr) | {er, e};
    nmask  = (wr && a == 2'd1) ? wd : m_mask;
    if (er && (!m_flags[8] || clr[8])) ncause = code;
    else if (clr[8])                   ncause = 4'hF;
    else                               ncause = m_cause;
    nirq   = |(m_flags & m_mask);
    @(posedge clk);
    m_flags = nflags; m_mask = nmask; m_cause = ncause; m_irq = nirq;
  endtask

  task automatic idle(logic [1:0] a);
    drv(1'b0, a, 9'd0, 8'd0, 1'b0, 4'd11, busy);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    // R1: reset values
    repeat (3) @(negedge clk);
    #0.5;
    reg_addr = 2'd0; #0.1;
    chk("R1 flags at reset", {23'd0, rdata[8:0]}, 32'd0);
    chk("R1 cause at reset", {28'd0, rdata[27:24]}, 32'hF);
    chk("R1 irq at reset", {31'd0, irq}, 32'd0);
    reg_addr = 2'd1; #0.1;
    chk("R1 mask at reset", rdata, 32'd0);
    rst_ni = 1'b1;

    // R2: each event sets its own bit, R3: write-0 keeps, write-1 clears
    for (int k = 0; k < 8; k++) drv(1'b0, 2'd0, 9'd0, 8'(1 << k), 1'b0, 4'd11, 1'b0);
    idle(2'd0);
    drv(1'b1, 2'd0, 9'd0, 8'd0, 1'b0, 4'd11, 1'b0);
    idle(2'd0);
    drv(1'b1, 2'd0, 9'h055, 8'd0, 1'b0, 4'd11, 1'b1);
    idle(2'd0);
    // R4: set and clear of bit 1 in the same cycle
    drv(1'b1, 2'd0, 9'h0FF, 8'h02, 1'b0, 4'd11, 1'b0);
    idle(2'd0);
    // R5/R6: mask then irq
    drv(1'b1, 2'd1, 9'h002, 8'd0, 1'b0, 4'd11, 1'b0);
    idle(2'd1); idle(2'd0); idle(2'd0);
    drv(1'b1, 2'd0, 9'h002, 8'd0, 1'b0, 4'd11, 1'b0);
    idle(2'd0); idle(2'd0);
    // R7/R8: first error captured, second ignored
    drv(1'b0, 2'd0, 9'd0, 8'd0, 1'b1, 4'd13, 1'b0);
    idle(2'd0);
    drv(1'b0, 2'd0, 9'd0, 8'd0, 1'b1, 4'd12, 1'b0);
    idle(2'd0);
    // R11: write to status cannot touch cause
    drv(1'b1, 2'd0, 9'h0FF, 8'd0, 1'b0, 4'd11, 1'b1);
    idle(2'd0);
    // R9: clear racing a new error, then plain clear
    drv(1'b1, 2'd0, 9'h100, 8'd0, 1'b1, 4'd14, 1'b0);
    idle(2'd0);
    drv(1'b1, 2'd0, 9'h100, 8'd0, 1'b0, 4'd11, 1'b0);
    idle(2'd0);
    // R12: unmapped writes ignored
    drv(1'b1, 2'd2, 9'h1FF, 8'd0, 1'b0, 4'd11, 1'b0);
    drv(1'b1, 2'd3, 9'h1FF, 8'd0, 1'b0, 4'd11, 1'b0);
    idle(2'd1); idle(2'd0);

    // randomized collisions
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] e;
      e = '0;
      for (int k = 0; k < 8; k++) e[k] = ($urandom_range(7) == 0);
      drv(($urandom_range(2) == 0), 2'($urandom_range(3)), 9'($urandom),
          e, ($urandom_range(5) == 0), 4'(11 + $urandom_range(3)),
          1'($urandom));
    end
    done = 1;
    summary();
  end
endmodule